// File: doc/BRIEF.md
# Indexed Postbyte Effective-Address Unit

This unit turns a one-byte indexed-addressing postbyte into a 16-bit effective address. A request is a one-cycle `start` pulse carrying the postbyte, the four base registers (X, Y, SP and PC), the two 8-bit accumulators and a `restricted` flag. All of these are captured on the accepting edge. Five encodings are decoded:

- a short signed constant;
- auto-modify of a base register, before or after use;
- a byte or 16-bit constant that comes from an extension stream;
- an accumulator offset;
- two memory-indirect forms that read a 16-bit pointer.

Extension bytes arrive on a valid/ready stream. Pointers come from a 16-bit read port that holds its request until the data is valid. The result appears as a one-cycle `done` pulse. With it come the address, an optional register write-back for the auto-modify forms, an extra-cycle flag, and a fault flag for forms that restricted mode rejects. The caller supplies PC already adjusted to whatever value the instruction flow defines. Instruction sequencing and the final data access belong to the surrounding core.

Top module: `idx_addr_gen`

## Requirements
- R1: With postbyte bit 5 clear, the address is base plus bits 4:0 taken as a signed 5-bit value, where bits 7:6 pick the base (0 X, 1 Y, 2 SP, 3 PC). `done` rises in the cycle after the accepting edge, and `extra_cycle` is 0.
- R2: With bit 5 set and bits 7:6 not 11, the auto-modify amount is bits 3:0 sign-extended when bit 3 is set, and bits 3:0 plus one (1 to 8) when bit 3 is clear.
- R3: In auto-modify, `wb_en` pulses with `done`, `wb_sel` equals bits 7:6, and `wb_val` is the old register plus the amount. The address is the new value when bit 4 is 0 and the old value when bit 4 is 1.
- R4: With bits 7:6 equal to 11, bits 4:3 pick the base using the same 0 to 3 mapping.
- R5: With bits 7:6 = 11, bit 2 = 0 and bits 2:0 not 011, bit 1 set fetches two extension bytes, high byte first. Bit 1 clear fetches one byte, and its upper byte is FF if bit 0 is set and 00 otherwise. The address is base plus that offset, and `extra_cycle` is 1. Bytes are taken only on cycles where `ext_ready` and `ext_valid` are both high.
- R6: With bits 7:6 = 11 and bits 2:0 = 011, two extension bytes (high first) are added to the base. `rd_addr` carries that sum and stays stable while `rd_req` waits for `rd_valid`. The address is `rd_data`, and `extra_cycle` is 1.
- R7: With bits 7:6 = 11 and bit 2 = 1, bits 1:0 select the offset: 0 is A zero-extended, 1 is B zero-extended, 2 is D = {A,B}. Value 3 reads a pointer at base+D and returns it with `extra_cycle` 1. The other three return with `extra_cycle` 0.
- R8: When `restricted` is high, the forms of R5 and R6 complete in the cycle after acceptance with `fault` 1, address 0, no write-back, `extra_cycle` 0, and no extension byte consumed.
- R9: When `restricted` is high, the forms of R1, R2, R3 and R7 complete normally with `fault` 0.
- R10: All address and write-back arithmetic wraps modulo 2^16.
- R11: `start` is ignored while `busy` is high, so it produces neither an extra result nor a change to the pending one.
- R12: After reset, `done`, `fault`, `wb_en`, `ext_ready`, `rd_req` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| postbyte | input | 8 | Indexed-addressing postbyte |
| restricted | input | 1 | Reject extension-constant and 16-bit indirect forms |
| reg_x | input | 16 | Base register X |
| reg_y | input | 16 | Base register Y |
| reg_sp | input | 16 | Stack pointer base |
| reg_pc | input | 16 | Program counter base |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| ext_ready | output | 1 | Unit is waiting for an extension byte |
| ext_valid | input | 1 | Extension byte present |
| ext_byte | input | 8 | Extension byte |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_valid | input | 1 | Pointer read data valid |
| rd_data | input | 16 | Pointer read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base register write-back strobe |
| wb_sel | output | 2 | Register to write back (0 X, 1 Y, 2 SP, 3 PC) |
| wb_val | output | 16 | Write-back value |
| extra_cycle | output | 1 | Form costs one additional cycle |
| fault | output | 1 | Form rejected in restricted mode |

## Verification
The hardest situation to reach is a second `start` arriving while the unit is parked in a fetch or read wait. An accepted request returns in one cycle unless it is waiting on a byte or on memory, so that window is short. The stimulus opens the window by pacing the byte stream every other cycle and delaying each read response by two cycles. It then pulses `start` again during a 16-bit constant fetch. The scoreboard must see exactly one result, with the original offset. The same slow responders also hold `rd_req` open across several edges, which exposes any drift in the read address.

// File: rtl/idxgen_pkg.sv
package idxgen_pkg;

   typedef enum logic [1:0] {
      BASE_X  = 2'd0,
      BASE_Y  = 2'd1,
      BASE_SP = 2'd2,
      BASE_PC = 2'd3
   } base_sel_t;

   typedef enum logic [2:0] {
      F_CONST5    = 3'd0,
      F_AUTOMOD   = 3'd1,
      F_CONST_EXT = 3'd2,
      F_IND_EXT   = 3'd3,
      F_ACC       = 3'd4,
      F_IND_ACC   = 3'd5
   } form_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HI   = 2'd1,
      ST_LO   = 2'd2,
      ST_RD   = 2'd3
   } st_t;

   typedef struct packed {
      form_t     form;
      base_sel_t base;
      logic      wide;
      logic      sign_hi;
      logic      post;
      logic      forbidden;
      logic [1:0] acc_sel;
   } dec_t;

endpackage

// File: rtl/idxgen_decode.sv
module idxgen_decode
   import idxgen_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [7:0]    pb,
   output dec_t          dec,
   output logic [AW-1:0] small_off
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("idxgen_decode: AW must be at least 8");
      end
   endgenerate

   always_comb begin
      dec       = '0;
      small_off = '0;
      if (!pb[5]) begin
         dec.form  = F_CONST5;
         dec.base  = base_sel_t'(pb[7:6]);
         small_off = {{(AW-5){pb[4]}}, pb[4:0]};
      end else if (pb[7:6] != 2'b11) begin
         dec.form = F_AUTOMOD;
         dec.base = base_sel_t'(pb[7:6]);
         dec.post = pb[4];
         if (pb[3]) small_off = {{(AW-4){1'b1}}, pb[3:0]};
         else       small_off = {{(AW-3){1'b0}}, pb[2:0]} + {{(AW-1){1'b0}}, 1'b1};
      end else begin
         dec.base = base_sel_t'(pb[4:3]);
         if (pb[2:0] == 3'b011) begin
            dec.form      = F_IND_EXT;
            dec.wide      = 1'b1;
            dec.forbidden = 1'b1;
         end else if (!pb[2]) begin
            dec.form      = F_CONST_EXT;
            dec.wide      = pb[1];
            dec.sign_hi   = pb[0];
            dec.forbidden = 1'b1;
         end else begin
            dec.acc_sel = pb[1:0];
            dec.form    = (pb[1:0] == 2'b11) ? F_IND_ACC : F_ACC;
         end
      end
   end

endmodule

// File: rtl/idxgen_base_mux.sv
module idxgen_base_mux #(
   parameter int AW    = 16,
   parameter int NBASE = 4,
   localparam int SW   = $clog2(NBASE)
) (
   input  logic [NBASE*AW-1:0] flat,
   input  logic [SW-1:0]       sel,
   output logic [AW-1:0]       q
);

   logic [AW-1:0] slot [NBASE];

   generate
      if (NBASE < 2) begin : g_bad_n
         $error("idxgen_base_mux: NBASE must be at least 2");
      end
      for (genvar i = 0; i < NBASE; i++) begin : g_slot
         assign slot[i] = flat[i*AW +: AW];
      end
   endgenerate

   assign q = slot[sel];

endmodule

// File: rtl/idxgen_acc_off.sv
module idxgen_acc_off #(
   parameter int BW         = 8,
   parameter bit SIGNED_ACC = 1'b0,
   localparam int AW        = 2 * BW
) (
   input  logic [BW-1:0] a,
   input  logic [BW-1:0] b,
   input  logic [1:0]    sel,
   output logic [AW-1:0] off
);

   logic [AW-1:0] ext_a;
   logic [AW-1:0] ext_b;

   generate
      if (SIGNED_ACC) begin : g_sext
         assign ext_a = {{BW{a[BW-1]}}, a};
         assign ext_b = {{BW{b[BW-1]}}, b};
      end else begin : g_zext
         assign ext_a = {{BW{1'b0}}, a};
         assign ext_b = {{BW{1'b0}}, b};
      end
   endgenerate

   always_comb begin
      case (sel)
         2'd0:    off = ext_a;
         2'd1:    off = ext_b;
         default: off = {a, b};
      endcase
   end

endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
   import idxgen_pkg::*;
#(
   parameter int BW         = 8,
   parameter bit SIGNED_ACC = 1'b0,
   localparam int AW        = 2 * BW,
   localparam int NBASE     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    postbyte,
   input  logic          restricted,
   input  logic [AW-1:0] reg_x,
   input  logic [AW-1:0] reg_y,
   input  logic [AW-1:0] reg_sp,
   input  logic [AW-1:0] reg_pc,
   input  logic [BW-1:0] acc_a,
   input  logic [BW-1:0] acc_b,
   output logic          ext_ready,
   input  logic          ext_valid,
   input  logic [BW-1:0] ext_byte,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_valid,
   input  logic [AW-1:0] rd_data,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] ea,
   output logic          wb_en,
   output logic [1:0]    wb_sel,
   output logic [AW-1:0] wb_val,
   output logic          extra_cycle,
   output logic          fault
);

   generate
      if (BW != 8) begin : g_bad_bw
         $error("idx_addr_gen: the postbyte offsets assume an 8-bit byte");
      end
   endgenerate

   dec_t          dec, dec_q;
   logic [AW-1:0] small_off;
   logic [AW-1:0] base_val, base_q;
   logic [AW-1:0] acc_off;
   logic [AW-1:0] sum_small, acc_sum, ext_sum;
   logic [BW-1:0] off_hi_q;
   logic [AW-1:0] addr_q;
   st_t           st;

   idxgen_decode #(.AW(AW)) u_dec (
      .pb        (postbyte),
      .dec       (dec),
      .small_off (small_off)
   );

   idxgen_base_mux #(.AW(AW), .NBASE(NBASE)) u_base (
      .flat ({reg_pc, reg_sp, reg_y, reg_x}),
      .sel  (dec.base),
      .q    (base_val)
   );

   idxgen_acc_off #(.BW(BW), .SIGNED_ACC(SIGNED_ACC)) u_acc (
      .a   (acc_a),
      .b   (acc_b),
      .sel (dec.acc_sel),
      .off (acc_off)
   );

   assign sum_small = base_val + small_off;
   assign acc_sum   = base_val + acc_off;
   assign ext_sum   = base_q + {off_hi_q, ext_byte};

   assign busy      = (st != ST_IDLE);
   assign ext_ready = (st == ST_HI) || (st == ST_LO);
   assign rd_req    = (st == ST_RD);
   assign rd_addr   = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         dec_q       <= '0;
         base_q      <= '0;
         off_hi_q    <= '0;
         addr_q      <= '0;
         done        <= 1'b0;
         ea          <= '0;
         wb_en       <= 1'b0;
         wb_sel      <= 2'd0;
         wb_val      <= '0;
         extra_cycle <= 1'b0;
         fault       <= 1'b0;
      end else begin
         done  <= 1'b0;
         wb_en <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  dec_q  <= dec;
                  base_q <= base_val;
                  if (restricted && dec.forbidden) begin
                     done        <= 1'b1;
                     fault       <= 1'b1;
                     ea          <= '0;
                     extra_cycle <= 1'b0;
                  end else begin
                     case (dec.form)
                        F_CONST5: begin
                           done        <= 1'b1;
                           fault       <= 1'b0;
                           ea          <= sum_small;
                           extra_cycle <= 1'b0;
                        end
                        F_AUTOMOD: begin
                           done        <= 1'b1;
                           fault       <= 1'b0;
                           ea          <= dec.post ? base_val : sum_small;
                           wb_en       <= 1'b1;
                           wb_sel      <= dec.base;
                           wb_val      <= sum_small;
                           extra_cycle <= 1'b0;
                        end
                        F_ACC: begin
                           done        <= 1'b1;
                           fault       <= 1'b0;
                           ea          <= acc_sum;
                           extra_cycle <= 1'b0;
                        end
                        F_IND_ACC: begin
                           addr_q <= acc_sum;
                           st     <= ST_RD;
                        end
                        default: begin
                           if (dec.wide) begin
                              st <= ST_HI;
                           end else begin
                              off_hi_q <= {BW{dec.sign_hi}};
                              st       <= ST_LO;
                           end
                        end
                     endcase
                  end
               end
            end
            ST_HI: begin
               if (ext_valid) begin
                  off_hi_q <= ext_byte;
                  st       <= ST_LO;
               end
            end
            ST_LO: begin
               if (ext_valid) begin
                  if (dec_q.form == F_IND_EXT) begin
                     addr_q <= ext_sum;
                     st     <= ST_RD;
                  end else begin
                     done        <= 1'b1;
                     fault       <= 1'b0;
                     ea          <= ext_sum;
                     extra_cycle <= 1'b1;
                     st          <= ST_IDLE;
                  end
               end
            end
            default: begin
               if (rd_valid) begin
                  done        <= 1'b1;
                  fault       <= 1'b0;
                  ea          <= rd_data;
                  extra_cycle <= 1'b1;
                  st          <= ST_IDLE;
               end
            end
         endcase
      end
   end

   // write-back only ever accompanies a result
   assert_wb_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);

   // a rejected form leaves nothing behind
   assert_fault_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (ea == '0 && !wb_en && !extra_cycle));

   // byte stream and memory port are never requested together
   assert_one_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_ready && rd_req));

   // pending read keeps its address
   assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

   // no result without having been busy or just started
   assert_done_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(start) || $past(busy)));

endmodule

// File: tb/sim_idx_addr_gen.sv
module sim_idx_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  postbyte = 8'h00;
   logic        restricted = 1'b0;
   logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3FF0, reg_pc = 16'h8000;
   logic [7:0]  acc_a = 8'h12, acc_b = 8'hF4;
   logic        ext_ready, ext_valid = 1'b0;
   logic [7:0]  ext_byte = 8'h00;
   logic        rd_req, rd_valid = 1'b0;
   logic [15:0] rd_addr, rd_data = 16'h0000;
   logic        busy, done, wb_en, extra_cycle, fault;
   logic [15:0] ea, wb_val;
   logic [1:0]  wb_sel;

   always #10 clk = ~clk;

   idx_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
      .restricted(restricted), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
      .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b), .ext_ready(ext_ready),
      .ext_valid(ext_valid), .ext_byte(ext_byte), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
      .done(done), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
      .extra_cycle(extra_cycle), .fault(fault)
   );

   typedef struct {
      logic [15:0] ea;
      logic        wb_en;
      logic [1:0]  wb_sel;
      logic [15:0] wb_val;
      logic        extra;
      logic        fault;
      string       tag;
   } exp_t;

   exp_t       sb[$];
   logic [7:0] bq[$];
   int         n_chk = 0;
   int         n_bad = 0;
   int         cyc = 0;
   bit         hs_pend = 0;
   bit         gap = 0;
   int         rd_wait = 0;

   function automatic logic [15:0] mem16(input logic [15:0] adr);
      return {adr[7:0] ^ 8'hC3, adr[15:8] + 8'h17};
   endfunction

   function automatic logic [15:0] pick(input logic [1:0] s);
      case (s)
         2'd0: return reg_x;
         2'd1: return reg_y;
         2'd2: return reg_sp;
         default: return reg_pc;
      endcase
   endfunction

   // extension byte stream, paced every other cycle
   always @(negedge clk) begin
      if (hs_pend) void'(bq.pop_front());
      gap = ~gap;
      ext_valid = (bq.size() > 0) && !gap;
      ext_byte  = (bq.size() > 0) ? bq[0] : 8'h00;
      hs_pend   = ext_valid && ext_ready;
   end

   // pointer memory, answering on the third cycle of a request
   always @(negedge clk) begin
      if (rd_req) begin
         rd_wait++;
         if (rd_wait >= 3) begin
            rd_valid = 1'b1;
            rd_data  = mem16(rd_addr);
         end
      end else begin
         rd_wait  = 0;
         rd_valid = 1'b0;
      end
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         n_chk++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R11 unexpected result ea=%h expected no result", ea);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (ea !== e.ea || wb_en !== e.wb_en || extra_cycle !== e.extra ||
                fault !== e.fault ||
                (e.wb_en && (wb_sel !== e.wb_sel || wb_val !== e.wb_val))) begin
               n_bad++;
               $display("FAIL %s actual ea=%h wb=%b/%0d/%h x=%b f=%b expected ea=%h wb=%b/%0d/%h x=%b f=%b",
                        e.tag, ea, wb_en, wb_sel, wb_val, extra_cycle, fault,
                        e.ea, e.wb_en, e.wb_sel, e.wb_val, e.extra, e.fault);
            end
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic issue(input logic [7:0] pb, input logic r, input logic [7:0] hi,
                        input logic [7:0] lo, input string tag, input bit poke = 1'b0);
      exp_t        e;
      logic [15:0] base, amt, nv, off;
      e.wb_en = 0; e.wb_sel = 0; e.wb_val = 0; e.extra = 0; e.fault = 0; e.tag = tag;
      if (!pb[5]) begin
         base = pick(pb[7:6]);
         e.ea = base + {{11{pb[4]}}, pb[4:0]};
      end else if (pb[7:6] != 2'b11) begin
         base = pick(pb[7:6]);
         amt  = pb[3] ? {12'hFFF, pb[3:0]} : ({12'h000, pb[3:0]} + 16'd1);
         nv   = base + amt;
         e.ea = pb[4] ? base : nv;
         e.wb_en = 1; e.wb_sel = pb[7:6]; e.wb_val = nv;
      end else begin
         base = pick(pb[4:3]);
         if (pb[2:0] == 3'b011 || !pb[2]) begin
            if (r) begin
               e.ea = 16'h0000; e.fault = 1;
            end else begin
               if (pb[2:0] == 3'b011 || pb[1]) begin
                  off = {hi, lo}; bq.push_back(hi); bq.push_back(lo);
               end else begin
                  off = {pb[0] ? 8'hFF : 8'h00, lo}; bq.push_back(lo);
               end
               e.ea = (pb[2:0] == 3'b011) ? mem16(base + off) : base + off;
               e.extra = 1;
            end
         end else begin
            case (pb[1:0])
               2'd0: e.ea = base + {8'h00, acc_a};
               2'd1: e.ea = base + {8'h00, acc_b};
               2'd2: e.ea = base + {acc_a, acc_b};
               default: begin e.ea = mem16(base + {acc_a, acc_b}); e.extra = 1; end
            endcase
         end
      end
      sb.push_back(e);
      @(negedge clk);
      postbyte = pb; restricted = r; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke && busy) begin
         postbyte = 8'h05; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (done !== 1'b0 || fault !== 1'b0 || wb_en !== 1'b0 || ext_ready !== 1'b0 ||
          rd_req !== 1'b0 || busy !== 1'b0) begin
         n_bad++;
         $display("FAIL R12 reset outputs d=%b f=%b w=%b er=%b rr=%b b=%b expected all 0",
                  done, fault, wb_en, ext_ready, rd_req, busy);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R1 short signed constant on each base
      issue(8'h05, 0, 8'h00, 8'h00, "R1 X+5");
      issue(8'h5F, 0, 8'h00, 8'h00, "R1 Y-1");
      issue(8'h90, 0, 8'h00, 8'h00, "R1 SP-16");
      issue(8'hCF, 0, 8'h00, 8'h00, "R1 PC+15");
      // R2 R3 auto-modify
      issue(8'h20, 0, 8'h00, 8'h00, "R2 R3 X pre +1");
      issue(8'h37, 0, 8'h00, 8'h00, "R2 R3 X post +8");
      issue(8'h68, 0, 8'h00, 8'h00, "R2 R3 Y pre -8");
      issue(8'hBF, 0, 8'h00, 8'h00, "R2 R3 SP post -1");
      issue(8'hA7, 0, 8'h00, 8'h00, "R2 R3 SP pre +8");
      // R4 R7 accumulator forms on each base
      issue(8'hE4, 0, 8'h00, 8'h00, "R4 R7 X+A");
      issue(8'hEC, 0, 8'h00, 8'h00, "R4 R7 Y+A");
      issue(8'hF5, 0, 8'h00, 8'h00, "R4 R7 SP+B zero-extended");
      issue(8'hFE, 0, 8'h00, 8'h00, "R4 R7 PC+D");
      issue(8'hE7, 0, 8'h00, 8'h00, "R7 pointer at X+D");
      // R5 extension constants
      issue(8'hE0, 0, 8'h00, 8'h40, "R5 X byte positive");
      issue(8'hE1, 0, 8'h00, 8'h80, "R5 X byte negative");
      issue(8'hEA, 0, 8'h12, 8'h34, "R5 Y 16-bit");
      issue(8'hF2, 0, 8'hC0, 8'h01, "R5 SP 16-bit");
      // R6 16-bit indirect
      issue(8'hE3, 0, 8'h01, 8'h00, "R6 pointer at X+0100");
      issue(8'hFB, 0, 8'hFF, 8'hFE, "R6 pointer at PC-2");
      // R8 restricted rejects
      issue(8'hE3, 1, 8'h00, 8'h00, "R8 indirect rejected");
      issue(8'hE0, 1, 8'h00, 8'h00, "R8 byte rejected");
      issue(8'hEA, 1, 8'h00, 8'h00, "R8 16-bit rejected");
      // R9 restricted allows others
      issue(8'h05, 1, 8'h00, 8'h00, "R9 constant allowed");
      issue(8'h37, 1, 8'h00, 8'h00, "R9 auto-modify allowed");
      issue(8'hE4, 1, 8'h00, 8'h00, "R9 accumulator allowed");
      issue(8'hE7, 1, 8'h00, 8'h00, "R9 D pointer allowed");
      // R10 wraparound
      reg_x = 16'hFFFE;
      issue(8'h03, 0, 8'h00, 8'h00, "R10 constant wrap");
      issue(8'h23, 0, 8'h00, 8'h00, "R10 auto-modify wrap");
      issue(8'hE2, 0, 8'hFF, 8'hF0, "R10 16-bit wrap");
      issue(8'hE6, 0, 8'h00, 8'h00, "R10 D wrap");
      reg_x = 16'h1000;
      // R11 start while busy
      issue(8'hEA, 0, 8'h0A, 8'h0B, "R11 start during fetch", 1'b1);
      issue(8'hE3, 0, 8'h00, 8'h10, "R11 start during read", 1'b1);

      repeat (5) @(negedge clk);
      n_chk++;
      if (sb.size() != 0 || bq.size() != 0) begin
         n_bad++;
         $display("FAIL R11 leftover results=%0d bytes=%0d expected 0 and 0", sb.size(), bq.size());
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule